// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a parameterised set of asynchronous external lines. It brings each line into the clock domain through two flip-flops and compares it with its value from the cycle before. When a line changes in a direction that software has enabled, the line's pending flag is set. Software can also set a pending flag directly through a trigger register. A pending flag stays set until software writes a 1 to its bit.

Pending flags feed two outputs. The interrupt request is the OR of every pending line whose interrupt enable is set. The wake-up event output gives a one-cycle pulse when a line whose event enable is set fires. Software controls the block through a 32-bit bus with byte offsets. Reads are combinational. Writes take effect at the clock edge. Register bits above the line count do not store anything and read as zero, so software can find the line count by writing all ones to a register and reading it back.

Top module: `eic_top`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `wake_evt_o` is 0.
- R2: The registers are mapped at these byte offsets: interrupt enable at 0x00, event enable at 0x04, rising-edge enable at 0x08, falling-edge enable at 0x0C, software trigger at 0x10 and pending at 0x14. Bit i of each register belongs to line i. A written enable value reads back unchanged in the implemented bits, and an unmapped offset reads 0.
- R3: Bits at positions NLINES and above do not store data and read 0. After all ones are written to the rising-edge enable register, the highest set bit of the value read back is at position NLINES, counting from 1.
- R4: A 0-to-1 change on a line whose rising-edge enable is 1 sets that line's pending bit. The bit is visible after the third clock edge that follows the input change. A pending bit is never set without an enabled edge or a software trigger.
- R5: A 1-to-0 change sets pending only when the line's falling-edge enable is 1, and a change in a direction that is not enabled has no effect. When both enables are 1, the line fires on both edges.
- R6: Writing 1 to a bit of the pending register clears that bit. Writing 0 leaves it unchanged.
- R7: A pending bit stays set until software clears it, even after further edges on the line or after its input goes back to its idle level.
- R8: `irq_o` is 1 exactly when some line has both its pending bit and its interrupt-enable bit set.
- R9: `wake_evt_o` is high for exactly one cycle, in the cycle after a line fires while its event-enable bit is 1. This happens whatever the line's interrupt-enable bit is.
- R10: Writing 1 to a software-trigger bit sets the matching pending bit at that clock edge, and the trigger bit then reads 1. The trigger bit returns to 0 when that pending bit is cleared.
- R11: If an edge fires on a line in the same cycle that a write of 1 clears its pending bit, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ext_lines | input | NLINES | Asynchronous external lines |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |
| wake_evt_o | output | 1 | One-cycle wake-up event pulse |

## Verification
The bench builds the block with NLINES = 20, which is fewer lines than the bus has bits. With that width, writes of all ones and of patterned data show that the upper twelve bits drop out, and the line-count probe returns 20 and not 32. Three lines are set up for rising only, falling only and both edges. This exercises each trigger mode against the opposite edge, and it lets the interrupt and event enables be split between lines. The software trigger provides a pending bit that is already set, so a real edge can be made to land in the same cycle as a clearing write.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_IRQ_EN  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_EVT_EN  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RISE_EN = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_SW_TRIG = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_PENDING = 5'h14;

  // Decide whether one line fires this cycle from its old and new sampled
  // levels and its two direction enables.
  function automatic logic edge_fires(input logic prev_lvl, input logic cur_lvl,
                                      input logic rise_on, input logic fall_on);
    edge_fires = (rise_on & ~prev_lvl & cur_lvl) | (fall_on & prev_lvl & ~cur_lvl);
  endfunction

  // Next pending state: the old state minus cleared bits, plus new fires.
  // A fire in the same cycle as a clear wins.
  function automatic logic next_pending(input logic cur, input logic clr, input logic fire);
    next_pending = (cur & ~clr) | fire;
  endfunction
endpackage

// File: rtl/eic_line_sync.sv
module eic_line_sync #(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lines_in,
  output logic [NLINES-1:0] cur_lvl,
  output logic [NLINES-1:0] prev_lvl
);
  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= lines_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign cur_lvl[i]  = sync_q;
    assign prev_lvl[i] = prev_q;
  end
endmodule

// File: rtl/eic_trigger.sv
module eic_trigger
  import eic_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic [NLINES-1:0] cur_lvl,
  input  logic [NLINES-1:0] prev_lvl,
  input  logic [NLINES-1:0] rise_en,
  input  logic [NLINES-1:0] fall_en,
  input  logic [NLINES-1:0] sw_set,
  output logic [NLINES-1:0] fire
);
  for (genvar i = 0; i < NLINES; i++) begin : g_fire
    assign fire[i] = edge_fires(prev_lvl[i], cur_lvl[i], rise_en[i], fall_en[i]) | sw_set[i];
  end
endmodule

// File: rtl/eic_regfile.sv
module eic_regfile
  import eic_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NLINES-1:0] fire,
  output logic [NLINES-1:0] irq_en,
  output logic [NLINES-1:0] evt_en,
  output logic [NLINES-1:0] rise_en,
  output logic [NLINES-1:0] fall_en,
  output logic [NLINES-1:0] pending,
  output logic [NLINES-1:0] sw_set,
  output logic [NLINES-1:0] clr
);
  logic [NLINES-1:0] wbits;
  logic [NLINES-1:0] sw_trig_q;

  assign wbits  = bus_wdata[NLINES-1:0];
  assign sw_set = (bus_wr && bus_addr == OFS_SW_TRIG) ? wbits : '0;
  assign clr    = (bus_wr && bus_addr == OFS_PENDING) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en  <= '0;
      evt_en  <= '0;
      rise_en <= '0;
      fall_en <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_IRQ_EN:  irq_en  <= wbits;
        OFS_EVT_EN:  evt_en  <= wbits;
        OFS_RISE_EN: rise_en <= wbits;
        OFS_FALL_EN: fall_en <= wbits;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[i]   <= 1'b0;
        sw_trig_q[i] <= 1'b0;
      end else begin
        pending[i]   <= next_pending(pending[i], clr[i], fire[i]);
        sw_trig_q[i] <= next_pending(sw_trig_q[i], clr[i], sw_set[i]);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_IRQ_EN:  bus_rdata[NLINES-1:0] = irq_en;
      OFS_EVT_EN:  bus_rdata[NLINES-1:0] = evt_en;
      OFS_RISE_EN: bus_rdata[NLINES-1:0] = rise_en;
      OFS_FALL_EN: bus_rdata[NLINES-1:0] = fall_en;
      OFS_SW_TRIG: bus_rdata[NLINES-1:0] = sw_trig_q;
      OFS_PENDING: bus_rdata[NLINES-1:0] = pending;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] ext_lines,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              wake_evt_o
);
  logic [NLINES-1:0] cur_lvl, prev_lvl;
  logic [NLINES-1:0] imask_q, emask_q, rise_q, fall_q;
  logic [NLINES-1:0] pend_q, sw_set_w, clr_w, trig_w;
  logic              evt_q;

  eic_line_sync #(.NLINES(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lines_in(ext_lines),
    .cur_lvl(cur_lvl), .prev_lvl(prev_lvl)
  );

  eic_trigger #(.NLINES(NLINES)) u_trig (
    .cur_lvl(cur_lvl), .prev_lvl(prev_lvl), .rise_en(rise_q),
    .fall_en(fall_q), .sw_set(sw_set_w), .fire(trig_w)
  );

  eic_regfile #(.NLINES(NLINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fire(trig_w),
    .irq_en(imask_q), .evt_en(emask_q), .rise_en(rise_q), .fall_en(fall_q),
    .pending(pend_q), .sw_set(sw_set_w), .clr(clr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= |(trig_w & emask_q);
  end

  assign irq_o      = |(pend_q & imask_q);
  assign wake_evt_o = evt_q;
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int unsigned NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              wake_evt_o,
  input logic [NLINES-1:0] pend_q,
  input logic [NLINES-1:0] imask_q,
  input logic [NLINES-1:0] emask_q,
  input logic [NLINES-1:0] trig_w,
  input logic [NLINES-1:0] clr_w
);
  AST_FIRE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_w) |=> (($past(trig_w) & ~pend_q) == '0)); // R11

  AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(trig_w)) == '0)); // R4

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(clr_w) & ~pend_q) == '0)); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_w) |=> (($past(clr_w) & ~$past(trig_w) & pend_q) == '0)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & imask_q) == '0) |-> !irq_o); // R8

  AST_EVT_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(trig_w & emask_q)) |=> wake_evt_o); // R9

  AST_EVT_ONLY_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(trig_w & emask_q)) |=> !wake_evt_o); // R9
endmodule

bind eic_top eic_checker #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .wake_evt_o(wake_evt_o),
  .pend_q(pend_q), .imask_q(imask_q), .emask_q(emask_q),
  .trig_w(trig_w), .clr_w(clr_w)
);

// File: tb/sim_eic_top.sv
`timescale 1ns/1ps
module sim_eic_top;
  localparam int NL = 20;
  localparam logic [4:0] A_IEN = 5'h00, A_EEN = 5'h04, A_REN = 5'h08,
                         A_FEN = 5'h0C, A_SWT = 5'h10, A_PND = 5'h14;

  // {offset, write data, expected read-back} for R2 / R3
  localparam logic [68:0] VECS [0:6] = '{
    {5'h00, 32'hFFFFFFFF, 32'h000FFFFF},
    {5'h04, 32'h12345678, 32'h00045678},
    {5'h08, 32'hFFFFFFFF, 32'h000FFFFF},
    {5'h0C, 32'hA5A5A5A5, 32'h0005A5A5},
    {5'h00, 32'h0000C3C3, 32'h0000C3C3},
    {5'h14, 32'hFFFFFFFF, 32'h00000000},
    {5'h18, 32'hFFFFFFFF, 32'h00000000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, wake_evt_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eic_top #(.NLINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_lines(lines), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wake_evt_o(wake_evt_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One-cycle write, starting and ending at a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // Change lines at a falling edge, then wait until after the third rising edge
  task automatic drive(input logic [NL-1:0] v);
    @(negedge clk);
    lines = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    int top;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4), r);
      check("R1 reset reg", r, 32'h0);
    end
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 evt", {31'b0, wake_evt_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 table walk
    for (int k = 0; k < 7; k++) begin
      wr(VECS[k][68:64], VECS[k][63:32]);
      rd(VECS[k][68:64], r);
      check("R2/R3 readback", r, VECS[k][31:0]);
    end
    // R3 line count from highest set bit
    wr(A_REN, 32'hFFFFFFFF);
    rd(A_REN, r);
    top = 0;
    for (int b = 0; b < 32; b++) if (r[b]) top = b + 1;
    check("R3 line count", 32'(top), 32'(NL));

    // line0 rising, line1 falling, line2 both; irq on line0, events on 1 and 3
    wr(A_REN, 32'h5);
    wr(A_FEN, 32'h6);
    wr(A_IEN, 32'h1);
    wr(A_EEN, 32'hA);

    drive(20'h1);
    rd(A_PND, r);
    check("R4 rising sets pending", r, 32'h1);
    check("R8 irq on enabled line", {31'b0, irq_o}, 32'h1);
    check("R9 no event on line0", {31'b0, wake_evt_o}, 32'h0);
    drive(20'h0);
    repeat (2) @(negedge clk);
    rd(A_PND, r);
    check("R7 stays pending", r, 32'h1);
    wr(A_PND, 32'h0);
    rd(A_PND, r);
    check("R6 write 0 no effect", r, 32'h1);
    wr(A_PND, 32'h1);
    rd(A_PND, r);
    check("R6 write 1 clears", r, 32'h0);
    check("R8 irq drops", {31'b0, irq_o}, 32'h0);

    drive(20'h2);
    repeat (2) @(negedge clk);
    rd(A_PND, r);
    check("R5 rising ignored on falling-only", r, 32'h0);
    drive(20'h0);
    rd(A_PND, r);
    check("R5 falling sets pending", r, 32'h2);
    check("R9 event pulse", {31'b0, wake_evt_o}, 32'h1);
    check("R8 masked line no irq", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R9 pulse one cycle", {31'b0, wake_evt_o}, 32'h0);
    wr(A_PND, 32'h2);

    drive(20'h4);
    rd(A_PND, r);
    check("R5 both: rise", r, 32'h4);
    wr(A_PND, 32'h4);
    drive(20'h0);
    rd(A_PND, r);
    check("R5 both: fall", r, 32'h4);
    wr(A_PND, 32'h4);

    // R10 software trigger on line3 (event enabled)
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_SWT; bus_wdata = 32'h8;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R10 sw trigger event", {31'b0, wake_evt_o}, 32'h1);
    rd(A_PND, r);
    check("R10 sw sets pending", r, 32'h8);
    rd(A_SWT, r);
    check("R10 trigger bit set", r, 32'h8);
    wr(A_PND, 32'h8);
    rd(A_SWT, r);
    check("R10 trigger bit self-clears", r, 32'h0);

    // R11 edge and clear in the same cycle
    wr(A_SWT, 32'h1);
    @(negedge clk);
    lines = 20'h1;
    repeat (2) @(posedge clk);
    wr(A_PND, 32'h1);
    rd(A_PND, r);
    check("R11 edge wins over clear", r, 32'h1);
    wr(A_PND, 32'h1);
    rd(A_PND, r);
    check("R11 later clear works", r, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule